// File: doc/BRIEF.md
# Tag-Chained Quadword DMA Channel

This block is one DMA channel that moves 128-bit quadwords from a memory read port to a data sink. Software sets up a small register set: control, memory address, quadword count, tag address and two return-address slots. It then sets the start bit. In counted mode the channel streams the programmed number of quadwords upward from the memory address and then stops.

In chained mode the channel reads a 128-bit tag from the tag address. The tag gives a type, a quadword count, an address field and an interrupt-request flag. The channel moves that tag's data, then works out where the next tag lives. Some tag types continue at the next sequential tag, some jump to the address field, one pair calls into and returns from a sub-list through a two-slot return stack, and some end the chain. A tag with its interrupt flag set suspends the channel after its data; setting start again resumes from the saved tag address.

An external per-channel inhibit holds a started channel before its first fetch. An optional mode forwards each tag's upper half to the sink ahead of its data. A one-cycle done pulse marks every completion or suspension.

Top module: `qw_chain_dma`

## Requirements
- R1: After synchronous reset every register reads zero, and `done`, `sink_valid` and `mem_req` are low.
- R2: Register selects are 0 control, 1 memory address, 2 count, 3 tag address, 4 return slot 0, 5 return slot 1. A control write keeps bits 8:0 (bit 8 start/busy, bit 7 tag-interrupt enable, bit 6 tag forwarding, bits 3:2 mode with 01 meaning chained and any other value counted, bit 0 direction) and is taken only while the channel is idle. Address writes clear bits 31 and 3:0. A count write keeps bits 15:0.
- R3: Starting counted mode with a count of zero completes at once: the count stays zero, the memory address is unchanged, the start bit clears and no sink beat appears.
- R4: Counted mode with count N delivers the N quadwords found at the memory address and upward in 16-byte steps, in order. It then leaves the address advanced by 16*N and the count at zero. A memory request holds `mem_req` and `mem_addr` until `mem_ack`, and `mem_rdata` is taken in the acknowledging cycle.
- R5: Chained mode ignores the programmed count and fetches a tag at the tag address. In the tag, bits 15:0 are the count, bits 30:28 the type, bit 31 the interrupt flag and bits 63:32 the address field (aligned as in R2). The type codes are refe 0, cnt 1, next 2, ref 3, refs 4, call 5, ret 6, end 7.
- R6: For ref, refs and refe the data is read from the address field. For every other type it is read from the quadwords straight after the tag.
- R7: After a cnt tag the next tag follows its data. After ref or refs the next tag is the one after the tag. A next tag jumps to its address field.
- R8: A call tag with a free slot writes the address after its data into the lowest free slot and jumps to its address field. With both slots full, the call ends the chain after its data. A ret tag pops the most recently filled slot, and with no slot filled it ends the chain after its data.
- R9: refe and end tags end the chain after their data. On any chain end the count is zero and the start bit is clear. The tag address then points past the tag for refe, and past the data for end and for an ending call or ret.
- R10: A tag with its interrupt flag set stops the channel after its data. The count is then zero, the memory address is just past that data, the tag address holds the next tag and the start bit is clear. The return slots are kept.
- R11: Setting the start bit again after a suspension continues the chain from the saved tag address with the saved return slots.
- R12: While `chan_inhibit` is high, a set start bit does not begin a transfer and the count keeps its programmed value. Once inhibit drops, the transfer proceeds.
- R13: With tag forwarding (control bit 6) set, each fetched tag produces one sink beat with `sink_is_tag` high and data equal to the tag's bits 127:64 in the low 64 bits, ahead of that tag's data beats.
- R14: `done` is high for exactly one cycle, the first cycle in which the start bit reads clear after a completion or suspension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write select |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 3 | Register read select |
| rd_data | output | 32 | Register read data for `rd_sel` |
| chan_inhibit | input | 1 | Holds a started channel before its first fetch |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the requested quadword |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 128 | Quadword read from memory |
| sink_valid | output | 1 | One sink beat this cycle |
| sink_is_tag | output | 1 | Beat carries a forwarded tag |
| sink_data | output | 128 | Beat payload |
| done | output | 1 | One-cycle completion or suspension pulse |

## Verification
Counted mode is tried with a zero count and with a three-quadword run, which separates the immediate-completion path from address stepping. One chain walks every tag type through a nested call and return. Its sequence of data quadwords tells apart each data-location rule and each next-tag rule, because a wrong choice fetches a differently numbered quadword. Separate chains fill both return slots, end on refe and on end, suspend midway with a pending return slot and then resume, hold under inhibit, and forward tags, so that each stop condition and each saved register value is compared against its own arithmetic expectation.

// File: rtl/qwdma_pkg.sv
package qwdma_pkg;

    localparam int ADDR_W = 32;
    localparam int QWC_W  = 16;
    localparam int QW_W   = 128;
    localparam logic [ADDR_W-1:0] QW_BYTES = 32'd16;

    typedef enum logic [2:0] {
        TT_REFE = 3'd0,
        TT_CNT  = 3'd1,
        TT_NEXT = 3'd2,
        TT_REF  = 3'd3,
        TT_REFS = 3'd4,
        TT_CALL = 3'd5,
        TT_RET  = 3'd6,
        TT_END  = 3'd7
    } tag_kind_e;

    typedef enum logic [2:0] {
        RS_CTRL  = 3'd0,
        RS_MADDR = 3'd1,
        RS_COUNT = 3'd2,
        RS_TADDR = 3'd3,
        RS_SLOT0 = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_DATA = 2'd2,
        ST_STEP = 2'd3
    } chan_state_e;

    typedef struct packed {
        logic [63:0]       upper;
        logic [ADDR_W-1:0] field;
        logic              irq;
        tag_kind_e         kind;
        logic [QWC_W-1:0]  qwc;
    } tag_fields_t;

    typedef struct packed {
        logic [ADDR_W-1:0] next_taddr;
        logic              push;
        logic              pop;
        logic              stop;
    } step_t;

    function automatic logic [ADDR_W-1:0] align_addr(input logic [ADDR_W-1:0] v);
        return {1'b0, v[ADDR_W-2:4], 4'b0000};
    endfunction

    function automatic logic data_at_field(input tag_kind_e k);
        return (k == TT_REF) || (k == TT_REFS) || (k == TT_REFE);
    endfunction

endpackage

// File: rtl/qwdma_tag_decode.sv
module qwdma_tag_decode
    import qwdma_pkg::*;
(
    input  logic [QW_W-1:0] raw,
    output tag_fields_t     fields
);
    always_comb begin
        fields.upper = raw[127:64];
        fields.field = align_addr(raw[63:32]);
        fields.irq   = raw[31];
        fields.kind  = tag_kind_e'(raw[30:28]);
        fields.qwc   = raw[QWC_W-1:0];
    end
endmodule

// File: rtl/qwdma_step_plan.sv
module qwdma_step_plan
    import qwdma_pkg::*;
#(
    parameter int RET_SLOTS = 2,
    localparam int SP_W = $clog2(RET_SLOTS + 1)
) (
    input  tag_kind_e         kind,
    input  logic [ADDR_W-1:0] taddr,
    input  logic [ADDR_W-1:0] maddr,
    input  logic [ADDR_W-1:0] field,
    input  logic [SP_W-1:0]   depth,
    input  logic [ADDR_W-1:0] top,
    output step_t             plan
);
    logic [ADDR_W-1:0] seq_tag;

    always_comb begin
        seq_tag         = taddr + QW_BYTES;
        plan.next_taddr = maddr;
        plan.push       = 1'b0;
        plan.pop        = 1'b0;
        plan.stop       = 1'b0;
        case (kind)
            TT_CNT:  plan.next_taddr = maddr;
            TT_NEXT: plan.next_taddr = field;
            TT_REF,
            TT_REFS: plan.next_taddr = seq_tag;
            TT_REFE: begin
                plan.next_taddr = seq_tag;
                plan.stop       = 1'b1;
            end
            TT_CALL: begin
                if (depth < SP_W'(RET_SLOTS)) begin
                    plan.push       = 1'b1;
                    plan.next_taddr = field;
                end else begin
                    plan.stop       = 1'b1;
                end
            end
            TT_RET: begin
                if (depth != '0) begin
                    plan.pop        = 1'b1;
                    plan.next_taddr = top;
                end else begin
                    plan.stop       = 1'b1;
                end
            end
            default: plan.stop = 1'b1;
        endcase
    end
endmodule

// File: rtl/qwdma_ret_stack.sv
module qwdma_ret_stack
    import qwdma_pkg::*;
#(
    parameter int RET_SLOTS = 2,
    localparam int SP_W = $clog2(RET_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 push,
    input  logic                 pop,
    input  logic [ADDR_W-1:0]    push_val,
    input  logic [RET_SLOTS-1:0] sw_wr,
    input  logic [ADDR_W-1:0]    sw_val,
    output logic [ADDR_W-1:0]    slot_q [RET_SLOTS],
    output logic [SP_W-1:0]      depth_q,
    output logic [ADDR_W-1:0]    top
);
    for (genvar i = 0; i < RET_SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (push && depth_q == SP_W'(i)) begin
                slot_q[i] <= push_val;
            end else if (sw_wr[i]) begin
                slot_q[i] <= align_addr(sw_val);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            depth_q <= '0;
        end else if (push) begin
            depth_q <= depth_q + 1'b1;
        end else if (pop) begin
            depth_q <= depth_q - 1'b1;
        end
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < RET_SLOTS; i++) begin
            if (depth_q == SP_W'(i + 1)) top = slot_q[i];
        end
    end
endmodule

// File: rtl/qw_chain_dma.sv
module qw_chain_dma
    import qwdma_pkg::*;
#(
    parameter int RET_SLOTS = 2,
    localparam int SP_W = $clog2(RET_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_sel,
    output logic [31:0]       rd_data,
    input  logic              chan_inhibit,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [QW_W-1:0]   mem_rdata,
    output logic              sink_valid,
    output logic              sink_is_tag,
    output logic [QW_W-1:0]   sink_data,
    output logic              done
);
    localparam int CTRL_W  = 9;
    localparam int BIT_RUN = 8;
    localparam int BIT_FWD = 6;

    chan_state_e       state_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [ADDR_W-1:0] maddr_q, taddr_q, field_q;
    logic [QWC_W-1:0]  count_q;
    tag_kind_e         kind_q;
    logic              irq_q;
    logic              chain_mode;

    tag_fields_t       dec;
    step_t             plan;
    logic [ADDR_W-1:0] slot_q [RET_SLOTS];
    logic [SP_W-1:0]   depth_q;
    logic [ADDR_W-1:0] stack_top;
    logic [RET_SLOTS-1:0] slot_wr;
    logic              in_step;

    assign chain_mode = (ctrl_q[3:2] == 2'b01);
    assign in_step    = (state_q == ST_STEP);

    qwdma_tag_decode u_dec (
        .raw    (mem_rdata),
        .fields (dec)
    );

    qwdma_step_plan #(.RET_SLOTS(RET_SLOTS)) u_plan (
        .kind  (kind_q),
        .taddr (taddr_q),
        .maddr (maddr_q),
        .field (field_q),
        .depth (depth_q),
        .top   (stack_top),
        .plan  (plan)
    );

    for (genvar i = 0; i < RET_SLOTS; i++) begin : g_slot_wr
        assign slot_wr[i] = wr_en && (wr_sel == 3'(RS_SLOT0 + i));
    end

    qwdma_ret_stack #(.RET_SLOTS(RET_SLOTS)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .clear    (in_step && plan.stop),
        .push     (in_step && plan.push),
        .pop      (in_step && plan.pop),
        .push_val (maddr_q),
        .sw_wr    (slot_wr),
        .sw_val   (wr_data),
        .slot_q   (slot_q),
        .depth_q  (depth_q),
        .top      (stack_top)
    );

    assign mem_req  = (state_q == ST_TAG) || (state_q == ST_DATA && count_q != '0);
    assign mem_addr = (state_q == ST_TAG) ? taddr_q : maddr_q;

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            RS_CTRL:  rd_data = {{(32-CTRL_W){1'b0}}, ctrl_q};
            RS_MADDR: rd_data = maddr_q;
            RS_COUNT: rd_data = {{(32-QWC_W){1'b0}}, count_q};
            RS_TADDR: rd_data = taddr_q;
            default: begin
                for (int i = 0; i < RET_SLOTS; i++) begin
                    if (rd_sel == 3'(RS_SLOT0 + i)) rd_data = slot_q[i];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            ctrl_q      <= '0;
            maddr_q     <= '0;
            taddr_q     <= '0;
            field_q     <= '0;
            count_q     <= '0;
            kind_q      <= TT_REFE;
            irq_q       <= 1'b0;
            sink_valid  <= 1'b0;
            sink_is_tag <= 1'b0;
            sink_data   <= '0;
            done        <= 1'b0;
        end else begin
            sink_valid <= 1'b0;
            done       <= 1'b0;
            if (wr_en) begin
                case (wr_sel)
                    RS_CTRL:  if (state_q == ST_IDLE) ctrl_q <= wr_data[CTRL_W-1:0];
                    RS_MADDR: maddr_q <= align_addr(wr_data);
                    RS_COUNT: count_q <= wr_data[QWC_W-1:0];
                    RS_TADDR: taddr_q <= align_addr(wr_data);
                    default: ;
                endcase
            end
            case (state_q)
                ST_IDLE: begin
                    if (ctrl_q[BIT_RUN] && !chan_inhibit)
                        state_q <= chain_mode ? ST_TAG : ST_DATA;
                end
                ST_TAG: begin
                    if (mem_ack) begin
                        kind_q  <= dec.kind;
                        irq_q   <= dec.irq;
                        field_q <= dec.field;
                        count_q <= dec.qwc;
                        maddr_q <= data_at_field(dec.kind) ? dec.field : taddr_q + QW_BYTES;
                        if (ctrl_q[BIT_FWD]) begin
                            sink_valid  <= 1'b1;
                            sink_is_tag <= 1'b1;
                            sink_data   <= {64'h0, dec.upper};
                        end
                        state_q <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (count_q == '0) begin
                        if (chain_mode) begin
                            state_q <= ST_STEP;
                        end else begin
                            ctrl_q[BIT_RUN] <= 1'b0;
                            done            <= 1'b1;
                            state_q         <= ST_IDLE;
                        end
                    end else if (mem_ack) begin
                        sink_valid  <= 1'b1;
                        sink_is_tag <= 1'b0;
                        sink_data   <= mem_rdata;
                        maddr_q     <= maddr_q + QW_BYTES;
                        count_q     <= count_q - 1'b1;
                    end
                end
                default: begin
                    taddr_q <= plan.next_taddr;
                    if (plan.stop || irq_q) begin
                        ctrl_q[BIT_RUN] <= 1'b0;
                        done            <= 1'b1;
                        state_q         <= ST_IDLE;
                    end else begin
                        state_q <= ST_TAG;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/qw_chain_dma_chk.sv
module qw_chain_dma_chk
    import qwdma_pkg::*;
#(
    parameter int RET_SLOTS = 2,
    localparam int SP_W = $clog2(RET_SLOTS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        state,
    input logic              busy,
    input logic [ADDR_W-1:0] maddr,
    input logic [ADDR_W-1:0] taddr,
    input logic [QWC_W-1:0]  count,
    input logic [SP_W-1:0]   depth,
    input logic              wr_en,
    input logic              chan_inhibit,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              sink_valid,
    input logic              done
);
    // R14: done only in the first cycle after busy dropped
    assert_done_after_busy_R14: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R2: address registers always keep the alignment
    assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        (maddr[3:0] == 4'h0) && !maddr[31] && (taddr[3:0] == 4'h0) && !taddr[31]);

    // R4: request held with a stable address until acknowledged
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R12: an inhibited start leaves the count untouched and stays idle
    assert_inhibit_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (state == 2'(ST_IDLE) && busy && chan_inhibit && !wr_en)
            |=> ($stable(count) && state == 2'(ST_IDLE)));

    // R8: the return stack never holds more than its slots
    assert_stack_bound_R8: assert property (@(posedge clk) disable iff (rst)
        depth <= SP_W'(RET_SLOTS));

    // R13: sink beats only come out of an active transfer
    assert_sink_active_R13: assert property (@(posedge clk) disable iff (rst)
        sink_valid |-> $past(state != 2'(ST_IDLE)));
endmodule

bind qw_chain_dma qw_chain_dma_chk #(.RET_SLOTS(RET_SLOTS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .state        (state_q),
    .busy         (ctrl_q[8]),
    .maddr        (maddr_q),
    .taddr        (taddr_q),
    .count        (count_q),
    .depth        (depth_q),
    .wr_en        (wr_en),
    .chan_inhibit (chan_inhibit),
    .mem_req      (mem_req),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .sink_valid   (sink_valid),
    .done         (done)
);

// File: tb/sim_qw_chain_dma.sv
module sim_qw_chain_dma;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_sel = '0;
    logic [31:0]  wr_data = '0;
    logic [2:0]   rd_sel = '0;
    logic [31:0]  rd_data;
    logic         chan_inhibit = 1'b0;
    logic         mem_req;
    logic [31:0]  mem_addr;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_rdata = '0;
    logic         sink_valid, sink_is_tag;
    logic [127:0] sink_data;
    logic         done;

    always #5 clk = ~clk;

    qw_chain_dma u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .chan_inhibit(chan_inhibit),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .sink_valid(sink_valid), .sink_is_tag(sink_is_tag), .sink_data(sink_data), .done(done)
    );

    logic [127:0] mem [256];
    logic [127:0] log_d [64];
    logic         log_t [64];
    int           log_n = 0;
    int           done_n = 0;
    int           n_chk = 0;
    int           n_err = 0;
    int           exp_idx [16];

    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[11:4]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (sink_valid && log_n < 64) begin
            log_d[log_n] = sink_data;
            log_t[log_n] = sink_is_tag;
            log_n++;
        end
        if (done) done_n++;
    end

    function automatic logic [127:0] qv(input int i);
        return {32'h3000_0000 + 32'(i), 32'h2000_0000 + 32'(i),
                32'h1000_0000 + 32'(i), 32'(i)};
    endfunction

    task automatic put_tag(input logic [31:0] at, input logic [2:0] kind,
                           input logic [15:0] qwc, input logic [31:0] field, input logic irq);
        mem[at[11:4]] = {32'hBEEF_0000, at, field, irq, kind, 12'h000, qwc};
    endtask

    task automatic check(input string r, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic wait_idle(input string r);
        logic [31:0] v;
        bit idle = 0;
        for (int k = 0; k < 3000 && !idle; k++) begin
            @(negedge clk);
            rd(3'd0, v);
            if (!v[8]) idle = 1;
        end
        check({r, " finishes"}, 128'(idle), 128'(1));
    endtask

    task automatic check_beats(input string r, input int base, input int n);
        check({r, " beat count"}, 128'(log_n - base), 128'(n));
        for (int k = 0; k < n; k++) begin
            if (base + k < log_n) begin
                check({r, " beat data"}, log_d[base + k], qv(exp_idx[k]));
                check({r, " beat kind"}, 128'(log_t[base + k]), 128'(0));
            end
        end
    endtask

    task automatic check_reg(input string r, input logic [2:0] sel, input logic [31:0] exp);
        logic [31:0] v;
        rd(sel, v);
        check(r, 128'(v), 128'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R14 watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int base, dn;
        for (int i = 0; i < 256; i++) mem[i] = qv(i);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int s = 0; s < 6; s++) check_reg("R1 reset reg", 3'(s), 32'h0);
        check("R1 done low", 128'(done), 128'(0));
        check("R1 sink low", 128'(sink_valid), 128'(0));
        check("R1 req low", 128'(mem_req), 128'(0));

        // R2: write masks
        wr(3'd0, 32'h5555_aaaa); check_reg("R2 ctrl mask", 3'd0, 32'h0000_00aa);
        wr(3'd0, 32'hffff_feff); check_reg("R2 ctrl mask", 3'd0, 32'h0000_00ff);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'hffff_ffff); check_reg("R2 maddr mask", 3'd1, 32'h7fff_fff0);
        wr(3'd2, 32'h5555_aaaa); check_reg("R2 count mask", 3'd2, 32'h0000_aaaa);
        wr(3'd3, 32'haaaa_5555); check_reg("R2 taddr mask", 3'd3, 32'h2aaa_5550);
        wr(3'd4, 32'h5555_aaaa); check_reg("R2 slot0 mask", 3'd4, 32'h5555_aaa0);
        wr(3'd5, 32'hffff_ffff); check_reg("R2 slot1 mask", 3'd5, 32'h7fff_fff0);
        for (int s = 1; s < 6; s++) wr(3'(s), 32'h0);

        // R3: counted mode, zero count
        base = log_n; dn = done_n;
        wr(3'd1, 32'h0000_0340); wr(3'd2, 32'h0);
        wr(3'd0, 32'h0000_0100);
        wait_idle("R3");
        check_reg("R3 count", 3'd2, 32'h0);
        check_reg("R3 maddr unchanged", 3'd1, 32'h0000_0340);
        check_reg("R3 start clear", 3'd0, 32'h0);
        check_beats("R3", base, 0);
        @(negedge clk);
        check("R14 one done pulse", 128'(done_n - dn), 128'(1));

        // R4: counted mode, three quadwords
        base = log_n;
        wr(3'd1, 32'h0000_0400); wr(3'd2, 32'd3);
        wr(3'd0, 32'h0000_0101);
        wait_idle("R4");
        for (int k = 0; k < 3; k++) exp_idx[k] = 'h40 + k;
        check_beats("R4", base, 3);
        check_reg("R4 maddr advanced", 3'd1, 32'h0000_0430);
        check_reg("R4 count", 3'd2, 32'h0);

        // R5 R6 R7 R8: chain through every type with nested call/ret
        put_tag(32'h100, 3'd1, 16'd2, 32'h0,   1'b0);
        put_tag(32'h130, 3'd2, 16'd1, 32'h200, 1'b0);
        put_tag(32'h200, 3'd3, 16'd2, 32'h600, 1'b0);
        put_tag(32'h210, 3'd5, 16'd1, 32'h300, 1'b0);
        put_tag(32'h300, 3'd5, 16'd0, 32'h380, 1'b0);
        put_tag(32'h380, 3'd4, 16'd1, 32'h700, 1'b0);
        put_tag(32'h390, 3'd6, 16'd1, 32'h0,   1'b0);
        put_tag(32'h310, 3'd6, 16'd0, 32'h0,   1'b0);
        put_tag(32'h230, 3'd6, 16'd1, 32'h0,   1'b0);
        base = log_n;
        wr(3'd2, 32'd51); wr(3'd3, 32'h100);
        wr(3'd0, 32'h0000_0104);
        wait_idle("R5");
        exp_idx[0] = 'h11; exp_idx[1] = 'h12; exp_idx[2] = 'h14;
        exp_idx[3] = 'h60; exp_idx[4] = 'h61; exp_idx[5] = 'h22;
        exp_idx[6] = 'h70; exp_idx[7] = 'h3a; exp_idx[8] = 'h24;
        check_beats("R6 R7 R8 chain order", base, 9);
        check_reg("R8 ret-empty maddr", 3'd1, 32'h0000_0250);
        check_reg("R9 ret-empty taddr", 3'd3, 32'h0000_0250);
        check_reg("R9 count", 3'd2, 32'h0);
        check_reg("R9 start clear", 3'd0, 32'h0000_0004);

        // R8: third call with both slots full ends the chain
        put_tag(32'h800, 3'd5, 16'd0, 32'h810, 1'b0);
        put_tag(32'h810, 3'd5, 16'd0, 32'h820, 1'b0);
        put_tag(32'h820, 3'd5, 16'd0, 32'h900, 1'b0);
        base = log_n;
        wr(3'd3, 32'h800); wr(3'd0, 32'h0000_0104);
        wait_idle("R8 full");
        check_reg("R8 slot0 pushed", 3'd4, 32'h0000_0810);
        check_reg("R8 slot1 pushed", 3'd5, 32'h0000_0820);
        check_reg("R8 full-call taddr", 3'd3, 32'h0000_0830);
        check_beats("R8 full", base, 0);

        // R9: refe ends after data fetched from the field
        put_tag(32'h900, 3'd0, 16'd2, 32'h680, 1'b0);
        base = log_n;
        wr(3'd3, 32'h900); wr(3'd0, 32'h0000_0104);
        wait_idle("R9 refe");
        exp_idx[0] = 'h68; exp_idx[1] = 'h69;
        check_beats("R9 refe", base, 2);
        check_reg("R9 refe maddr", 3'd1, 32'h0000_06a0);
        check_reg("R9 refe taddr", 3'd3, 32'h0000_0910);

        // R9: end tag ends after the data that follows it
        put_tag(32'h940, 3'd7, 16'd1, 32'h0, 1'b0);
        base = log_n;
        wr(3'd3, 32'h940); wr(3'd0, 32'h0000_0104);
        wait_idle("R9 end");
        exp_idx[0] = 'h95;
        check_beats("R9 end", base, 1);
        check_reg("R9 end maddr", 3'd1, 32'h0000_0960);
        check_reg("R9 end taddr", 3'd3, 32'h0000_0960);

        // R13: tag forwarding ahead of data
        base = log_n;
        wr(3'd3, 32'h900); wr(3'd0, 32'h0000_0144);
        wait_idle("R13");
        check("R13 beat count", 128'(log_n - base), 128'(3));
        check("R13 tag beat", log_d[base], {64'h0, 32'hBEEF_0000, 32'h0000_0900});
        check("R13 tag flag", 128'(log_t[base]), 128'(1));
        check("R13 data after tag", log_d[base + 1], qv('h68));
        check("R13 data flag", 128'(log_t[base + 1]), 128'(0));
        check("R13 second data", log_d[base + 2], qv('h69));

        // R10: suspend on the interrupt flag with a filled return slot
        put_tag(32'hA00, 3'd5, 16'd0, 32'hB00, 1'b0);
        put_tag(32'hB00, 3'd1, 16'd1, 32'h0,   1'b1);
        put_tag(32'hB20, 3'd6, 16'd0, 32'h0,   1'b0);
        put_tag(32'hA10, 3'd7, 16'd1, 32'h0,   1'b0);
        base = log_n; dn = done_n;
        wr(3'd3, 32'hA00); wr(3'd0, 32'h0000_0104);
        wait_idle("R10");
        exp_idx[0] = 'hb1;
        check_beats("R10", base, 1);
        check_reg("R10 count", 3'd2, 32'h0);
        check_reg("R10 maddr", 3'd1, 32'h0000_0b20);
        check_reg("R10 taddr", 3'd3, 32'h0000_0b20);
        check_reg("R10 start clear", 3'd0, 32'h0000_0004);
        @(negedge clk);
        check("R14 suspend pulse", 128'(done_n - dn), 128'(1));

        // R11: resume pops the saved slot
        base = log_n;
        wr(3'd0, 32'h0000_0104);
        wait_idle("R11");
        exp_idx[0] = 'ha2;
        check_beats("R11", base, 1);
        check_reg("R11 maddr", 3'd1, 32'h0000_0a30);
        check_reg("R11 taddr", 3'd3, 32'h0000_0a30);

        // R12: inhibit holds the start
        put_tag(32'hC00, 3'd7, 16'd0, 32'h0, 1'b0);
        base = log_n; dn = done_n;
        chan_inhibit = 1'b1;
        wr(3'd3, 32'hC00); wr(3'd2, 32'd51); wr(3'd0, 32'h0000_0104);
        repeat (20) @(negedge clk);
        check_reg("R12 count held", 3'd2, 32'd51);
        check_reg("R12 still started", 3'd0, 32'h0000_0104);
        check("R12 no beats", 128'(log_n - base), 128'(0));
        check("R12 no done", 128'(done_n - dn), 128'(0));
        chan_inhibit = 1'b0;
        wait_idle("R12 release");
        check_reg("R12 count after", 3'd2, 32'h0);
        check_reg("R12 taddr after", 3'd3, 32'h0000_0c10);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule